// File: doc/BRIEF.md
# Serial Channel Status Flag Register

This block is the status register that the processor sees for an asynchronous serial channel. It holds six sticky event flags: transmit buffer empty, receive buffer full, overrun, framing error, parity error and transmit done. It also holds two plain bits: the multiprocessor bit of the last accepted frame and the multiprocessor bit to send. The transmit and receive engines raise the flags with single-cycle pulses. A transfer controller lowers the buffer flags as a side effect of moving data.

Software clears a flag in two steps. First it reads the register and sees the flag at 1. Then it writes 0 to that bit. Each flag keeps a private armed bit to track this. A read that returns the flag as 1 sets the armed bit. The next 0-write to that bit uses it up. A hardware clear of the flag drops it. Writing 1 to a flag bit never changes anything. Three interrupt requests come from the flags: transmit, receive and error.

Top module: `serial_status_reg`

## Requirements
- R1: During and straight after reset, `rd_data[7:0]` reads 0x84. The bit layout is: bit 7 tx_empty, bit 6 rx_full, bit 5 overrun, bit 4 frame_err, bit 3 parity_err, bit 2 tx_done, bit 1 mp_rx, bit 0 mp_tx. After reset `tx_irq`=1, `rx_irq`=0 and `err_irq`=0.
- R2: A write with bit k at 0 clears sticky flag k (bits 7..2) only if an earlier read (`rd_en`) returned flag k as 1. A 0-write with no such read leaves the flag set. A 1-write never clears a flag.
- R3: A 0-write to a flag uses up its armed state, even when a hardware set wins that cycle. A later 0-write with no new read does not clear the flag.
- R4: A hardware clear of a flag drops its armed state. After the flag is set again, a 0-write with no new read does not clear it.
- R5: tx_empty is set while `tx_enable`=0 and on a `tx_load` pulse. It is cleared by `dmac_tx_wr`.
- R6: tx_done is set while `tx_enable`=0, and on `tx_last_bit` when tx_empty is 1. It is cleared by `dmac_tx_wr` and by the software clear of tx_empty, as well as by its own software clear.
- R7: A `rx_complete` pulse with no frame or parity error sets rx_full when rx_full is 0. `dmac_rx_rd` clears rx_full.
- R8: A `rx_complete` pulse sets overrun if rx_full is already 1. It sets frame_err if `rx_frame_bad` is high, and parity_err if `rx_parity_bad` is high.
- R9: When a hardware set and a clear reach the same flag in the same cycle, the flag ends at 1.
- R10: mp_rx loads `rx_mp_bit` only in the cycle rx_full is set by R7, and writes do not change it. mp_tx takes `wr_data[0]` on every write.
- R11: `tx_irq` equals tx_empty, `rx_irq` equals rx_full, and `err_irq` is the OR of overrun, frame_err and parity_err. With `IRQ_REG`=0 they change in the same cycle as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmitter enable level |
| tx_load | input | 1 | Pulse: transmit data moved into the shift register |
| tx_last_bit | input | 1 | Pulse: last bit of a character is being sent |
| rx_complete | input | 1 | Pulse: a received frame has ended |
| rx_frame_bad | input | 1 | Stop bit was 0 for the frame, qualified by rx_complete |
| rx_parity_bad | input | 1 | Parity mismatch for the frame, qualified by rx_complete |
| rx_mp_bit | input | 1 | Multiprocessor bit of the ending frame |
| dmac_tx_wr | input | 1 | Pulse: transfer controller wrote transmit data |
| dmac_rx_rd | input | 1 | Pulse: transfer controller read receive data |
| rd_en | input | 1 | Bus read strobe of this register |
| wr_en | input | 1 | Bus write strobe of this register |
| wr_data | input | BUS_W | Bus write data |
| rd_data | output | BUS_W | Register image, upper bits zero |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Receive error interrupt request |

## Verification
Every flag and plain bit is registered, so it shows in `rd_data` one clock edge after the pulse, read or write that moves it. The interrupt outputs show the same flags with no extra delay when `IRQ_REG`=0. An armed bit set by a read affects only writes in later cycles. The bench drives inputs 1 ns after a rising edge and compares 1 ns after the next rising edge, which is exactly one register stage later. It updates its expected image at that same point, so every comparison is made at the edge where the result is due.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
package ssr_pkg;
   localparam int FLD_W = 8;
   // bit positions of the register image
   localparam int B_TXE = 7;
   localparam int B_RXF = 6;
   localparam int B_OVR = 5;
   localparam int B_FRM = 4;
   localparam int B_PAR = 3;
   localparam int B_TXD = 2;
   localparam int B_MPR = 1;
   localparam int B_MPT = 0;
   // bits with read-then-write-0 clearing
   localparam logic [FLD_W-1:0] STICKY_MASK = 8'hFC;
   localparam logic [FLD_W-1:0] RESET_IMAGE = 8'h84;
endpackage

// File: rtl/ssr_flag_cell.sv
`timescale 1ns/1ps
// One sticky flag with its private armed bit.
module ssr_flag_cell #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_en,
   input  logic wr_zero,
   input  logic hw_set,
   input  logic hw_clr,
   output logic flag_o,
   output logic sw_clr_o
);
   logic flag_q, armed_q, flag_d, armed_d;

   assign sw_clr_o = wr_zero & armed_q;

   always_comb begin
      // a set wins over any clear in the same cycle
      flag_d  = hw_set | (flag_q & ~(hw_clr | sw_clr_o));
      // arm on a read that sees 1; consume on a 0-write; drop when cleared
      armed_d = flag_d & ((rd_en & flag_q) | (armed_q & ~wr_zero));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= RST_VAL;
         armed_q <= 1'b0;
      end else begin
         flag_q  <= flag_d;
         armed_q <= armed_d;
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/ssr_hold_bit.sv
`timescale 1ns/1ps
// Plain loadable bit.
module ssr_hold_bit #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic din,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST_VAL;
      else if (load) q <= din;
   end
endmodule

// File: rtl/ssr_irq_gen.sv
`timescale 1ns/1ps
module ssr_irq_gen #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       txe,
   input  logic       rxf,
   input  logic [2:0] errs,
   output logic       tx_irq,
   output logic       rx_irq,
   output logic       err_irq
);
   logic [2:0] raw;
   assign raw = {txe, rxf, |errs};

   generate
      if (REG_OUT) begin : g_reg
         logic [2:0] irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 3'b100;
            else        irq_q <= raw;
         end
         assign {tx_irq, rx_irq, err_irq} = irq_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign {tx_irq, rx_irq, err_irq} = raw;
      end
   endgenerate
endmodule

// File: rtl/serial_status_reg.sv
`timescale 1ns/1ps
module serial_status_reg
   import ssr_pkg::*;
#(
   parameter int BUS_W   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_enable,
   input  logic             tx_load,
   input  logic             tx_last_bit,
   input  logic             rx_complete,
   input  logic             rx_frame_bad,
   input  logic             rx_parity_bad,
   input  logic             rx_mp_bit,
   input  logic             dmac_tx_wr,
   input  logic             dmac_rx_rd,
   input  logic             rd_en,
   input  logic             wr_en,
   input  logic [BUS_W-1:0] wr_data,
   output logic [BUS_W-1:0] rd_data,
   output logic             tx_irq,
   output logic             rx_irq,
   output logic             err_irq
);
   localparam int PAD_W = BUS_W - FLD_W;

   generate
      if (BUS_W < FLD_W) begin : g_bad_width
         $error("serial_status_reg: BUS_W must be at least 8");
      end
   endgenerate

   logic [FLD_W-1:0] set_v, clr_v, swclr_v, flag_v;
   logic [1:0]       dat_v;
   logic             rx_accept;
   logic             unused_bits;

   assign unused_bits = ^{swclr_v[6:0], wr_data};

   always_comb begin
      set_v = '0;
      clr_v = '0;
      rx_accept = rx_complete & ~rx_frame_bad & ~rx_parity_bad & ~flag_v[B_RXF];
      set_v[B_TXE] = ~tx_enable | tx_load;
      clr_v[B_TXE] = dmac_tx_wr;
      set_v[B_TXD] = ~tx_enable | (tx_last_bit & flag_v[B_TXE]);
      clr_v[B_TXD] = dmac_tx_wr | swclr_v[B_TXE];
      set_v[B_RXF] = rx_accept;
      clr_v[B_RXF] = dmac_rx_rd;
      set_v[B_OVR] = rx_complete & flag_v[B_RXF];
      set_v[B_FRM] = rx_complete & rx_frame_bad;
      set_v[B_PAR] = rx_complete & rx_parity_bad;
      set_v[B_MPR] = rx_accept;
      set_v[B_MPT] = wr_en;
      dat_v[B_MPR] = rx_mp_bit;
      dat_v[B_MPT] = wr_data[0];
   end

   generate
      for (genvar k = 0; k < FLD_W; k++) begin : g_bit
         if (STICKY_MASK[k]) begin : g_sticky
            ssr_flag_cell #(.RST_VAL(RESET_IMAGE[k])) u_cell (
               .clk      (clk),
               .rst_n    (rst_n),
               .rd_en    (rd_en),
               .wr_zero  (wr_en & ~wr_data[k]),
               .hw_set   (set_v[k]),
               .hw_clr   (clr_v[k]),
               .flag_o   (flag_v[k]),
               .sw_clr_o (swclr_v[k])
            );
         end else begin : g_plain
            logic unused_clr;
            assign unused_clr = clr_v[k];
            assign swclr_v[k] = 1'b0;
            ssr_hold_bit #(.RST_VAL(RESET_IMAGE[k])) u_hold (
               .clk   (clk),
               .rst_n (rst_n),
               .load  (set_v[k]),
               .din   (dat_v[k]),
               .q     (flag_v[k])
            );
         end
      end

      if (PAD_W > 0) begin : g_pad
         assign rd_data = {{PAD_W{1'b0}}, flag_v};
      end else begin : g_nopad
         assign rd_data = flag_v;
      end
   endgenerate

   ssr_irq_gen #(.REG_OUT(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .txe     (flag_v[B_TXE]),
      .rxf     (flag_v[B_RXF]),
      .errs    (flag_v[B_OVR:B_PAR]),
      .tx_irq  (tx_irq),
      .rx_irq  (rx_irq),
      .err_irq (err_irq)
   );
endmodule

// File: rtl/ssr_checker.sv
`timescale 1ns/1ps
module ssr_checker #(
   parameter int BUS_W   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_enable,
   input logic             tx_load,
   input logic             rx_complete,
   input logic             dmac_tx_wr,
   input logic             wr_en,
   input logic [BUS_W-1:0] wr_data,
   input logic [BUS_W-1:0] rd_data,
   input logic             tx_irq,
   input logic             rx_irq,
   input logic             err_irq
);
   // R5 and R6: transmitter off forces both transmit flags high
   p_te_low_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_enable |=> (rd_data[7] && rd_data[2]));

   p_dmac_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_enable && !tx_load && dmac_tx_wr) |=> !rd_data[7]);

   p_one_write_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[5] && rd_data[5]) |=> rd_data[5]);

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_complete && rd_data[6]) |=> rd_data[5]);

   p_mp_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[0] == $past(wr_data[0])));

   generate
      if (!IRQ_REG) begin : g_irq_chk
         p_irq_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_irq == rd_data[7]) && (rx_irq == rd_data[6]) &&
            (err_irq == (rd_data[5] || rd_data[4] || rd_data[3])));
      end
   endgenerate
endmodule

bind serial_status_reg ssr_checker #(.BUS_W(BUS_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_enable   (tx_enable),
   .tx_load     (tx_load),
   .rx_complete (rx_complete),
   .dmac_tx_wr  (dmac_tx_wr),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .rd_data     (rd_data),
   .tx_irq      (tx_irq),
   .rx_irq      (rx_irq),
   .err_irq     (err_irq)
);

// File: tb/test_serial_status_reg.sv
`timescale 1ns/1ps
module test_serial_status_reg;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, tx_enable, tx_load, tx_last_bit, rx_complete, rx_frame_bad;
   logic rx_parity_bad, rx_mp_bit, dmac_tx_wr, dmac_rx_rd, rd_en, wr_en;
   logic [7:0] wr_data, rd_data;
   logic tx_irq, rx_irq, err_irq;

   int checks = 0;
   int fails  = 0;
   logic [7:0] m_f, m_arm, n_f, n_arm;

   serial_status_reg i_serial_status_reg (
      .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .tx_load(tx_load),
      .tx_last_bit(tx_last_bit), .rx_complete(rx_complete),
      .rx_frame_bad(rx_frame_bad), .rx_parity_bad(rx_parity_bad),
      .rx_mp_bit(rx_mp_bit), .dmac_tx_wr(dmac_tx_wr), .dmac_rx_rd(dmac_rx_rd),
      .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .tx_irq(tx_irq), .rx_irq(rx_irq), .err_irq(err_irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected next image, built from the requirement text
   task automatic predict();
      logic [7:0] st, cl, sw;
      st = '0; cl = '0; sw = '0;
      for (int k = 2; k < 8; k++) sw[k] = wr_en & ~wr_data[k] & m_arm[k];
      st[7] = ~tx_enable | tx_load;                 cl[7] = dmac_tx_wr;
      st[2] = ~tx_enable | (tx_last_bit & m_f[7]);  cl[2] = dmac_tx_wr | sw[7];
      st[6] = rx_complete & ~rx_frame_bad & ~rx_parity_bad & ~m_f[6];
      cl[6] = dmac_rx_rd;
      st[5] = rx_complete & m_f[6];
      st[4] = rx_complete & rx_frame_bad;
      st[3] = rx_complete & rx_parity_bad;
      n_f = m_f; n_arm = '0;
      for (int k = 2; k < 8; k++) begin
         if (st[k])              n_f[k] = 1'b1;
         else if (cl[k] | sw[k]) n_f[k] = 1'b0;
         n_arm[k] = n_f[k] & ((rd_en & m_f[k]) | (m_arm[k] & ~(wr_en & ~wr_data[k])));
      end
      if (st[6]) n_f[1] = rx_mp_bit;
      if (wr_en) n_f[0] = wr_data[0];
   endtask

   task automatic compare_all();
      chk("R5 tx_empty",  {7'd0, rd_data[7]}, {7'd0, m_f[7]});
      chk("R7 rx_full",   {7'd0, rd_data[6]}, {7'd0, m_f[6]});
      chk("R8 errors",    {5'd0, rd_data[5:3]}, {5'd0, m_f[5:3]});
      chk("R6 tx_done",   {7'd0, rd_data[2]}, {7'd0, m_f[2]});
      chk("R10 mp bits",  {6'd0, rd_data[1:0]}, {6'd0, m_f[1:0]});
      chk("R11 irqs", {5'd0, tx_irq, rx_irq, err_irq},
          {5'd0, m_f[7], m_f[6], |m_f[5:3]});
   endtask

   task automatic step();
      predict();
      @(posedge clk);
      #1;
      m_f = n_f; m_arm = n_arm;
      compare_all();
      tx_load = 0; tx_last_bit = 0; rx_complete = 0; rx_frame_bad = 0;
      rx_parity_bad = 0; dmac_tx_wr = 0; dmac_rx_rd = 0; rd_en = 0; wr_en = 0;
   endtask

   task automatic do_read();
      rd_en = 1; step();
   endtask

   task automatic do_write(input logic [7:0] d);
      wr_en = 1; wr_data = d; step();
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0; tx_enable = 1; tx_load = 0; tx_last_bit = 0; rx_complete = 0;
      rx_frame_bad = 0; rx_parity_bad = 0; rx_mp_bit = 0; dmac_tx_wr = 0;
      dmac_rx_rd = 0; rd_en = 0; wr_en = 0; wr_data = 0;
      m_f = 8'h84; m_arm = 0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset image", rd_data, 8'h84);
      chk("R1 reset irqs", {5'd0, tx_irq, rx_irq, err_irq}, 8'h04);
      rst_n = 1;
      step();
      chk("R1 after release", rd_data, 8'h84);

      // R6: software clear of tx_empty also clears tx_done
      do_read();
      do_write(8'h7F);
      chk("R2 tx_empty cleared", {7'd0, rd_data[7]}, 8'd0);
      chk("R6 tx_done linked clear", {7'd0, rd_data[2]}, 8'd0);
      chk("R10 mp_tx written", {7'd0, rd_data[0]}, 8'd1);
      // R5 / R6 hardware events
      tx_load = 1; step();
      chk("R5 load sets tx_empty", {7'd0, rd_data[7]}, 8'd1);
      tx_last_bit = 1; step();
      chk("R6 last bit sets tx_done", {7'd0, rd_data[2]}, 8'd1);
      dmac_tx_wr = 1; step();
      chk("R5 dmac clears", {6'd0, rd_data[7], rd_data[2]}, 8'd0);
      // R7 / R8 / R10 receive side
      rx_complete = 1; rx_mp_bit = 1; step();
      chk("R7 rx_full set", {7'd0, rd_data[6]}, 8'd1);
      chk("R10 mp_rx loaded", {7'd0, rd_data[1]}, 8'd1);
      rx_complete = 1; rx_mp_bit = 0; step();
      chk("R8 overrun set", {7'd0, rd_data[5]}, 8'd1);
      chk("R10 mp_rx held on overrun", {7'd0, rd_data[1]}, 8'd1);
      // R2: 0-write without a read does nothing
      do_write(8'h00);
      chk("R2 unarmed write keeps", {6'd0, rd_data[6:5]}, 8'd3);
      do_read();
      do_write(8'hDF);
      chk("R2 armed write clears", {6'd0, rd_data[6:5]}, 8'd2);
      // R9 then R3
      rx_complete = 1; step();
      do_read();
      rx_complete = 1; wr_en = 1; wr_data = 8'hDF; step();
      chk("R9 set wins", {7'd0, rd_data[5]}, 8'd1);
      do_write(8'hDF);
      chk("R3 armed consumed", {7'd0, rd_data[5]}, 8'd1);
      // R4: hardware clear drops armed state
      do_read();
      dmac_rx_rd = 1; step();
      chk("R7 dmac read clears", {7'd0, rd_data[6]}, 8'd0);
      rx_complete = 1; step();
      do_write(8'hBF);
      chk("R4 armed dropped", {7'd0, rd_data[6]}, 8'd1);
      // R8 error flags and R11 error interrupt
      do_read(); do_write(8'h00);
      rx_complete = 1; rx_frame_bad = 1; step();
      chk("R8 frame_err", {7'd0, rd_data[4]}, 8'd1);
      rx_complete = 1; rx_parity_bad = 1; step();
      chk("R8 parity_err", {7'd0, rd_data[3]}, 8'd1);
      chk("R11 err_irq", {7'd0, err_irq}, 8'd1);
      // transmitter off holds both transmit flags
      tx_enable = 0; step();
      chk("R5 te low", {6'd0, rd_data[7], rd_data[2]}, 8'd3);
      do_read(); do_write(8'h7B);
      chk("R9 te low beats clear", {6'd0, rd_data[7], rd_data[2]}, 8'd3);
      tx_enable = 1;

      for (int i = 0; i < 4000; i++) begin
         tx_enable     = ($urandom % 16) != 0;
         tx_load       = ($urandom % 8) == 0;
         tx_last_bit   = ($urandom % 6) == 0;
         rx_complete   = ($urandom % 6) == 0;
         rx_frame_bad  = ($urandom % 5) == 0;
         rx_parity_bad = ($urandom % 5) == 0;
         rx_mp_bit     = 1'($urandom);
         dmac_tx_wr    = ($urandom % 8) == 0;
         dmac_rx_rd    = ($urandom % 8) == 0;
         rd_en         = ($urandom % 3) == 0;
         wr_en         = ($urandom % 4) == 0;
         wr_data       = 8'($urandom);
         step();
      end
      finish_run();
   end
endmodule